// File: doc/BRIEF.md
# Key-Wrap Register Front End

This block is the host-facing register interface of a key-wrapping engine. The host bus is a plain chip-select / write-enable bus with an 8-bit address and 32-bit data. Through it the host sets the mode and the key length, loads up to eight key words, and sets the block count. It also loads the 64-bit integrity word, and can read it back once the engine has updated it. Control writes become single-cycle init and next pulses to the engine, and a status register shows the engine's ready and valid lines.

The data to be processed sits in an on-block store of 64-bit blocks, split into an upper bank and a lower bank. The host does not address this store directly. Every write to the load window places one 32-bit word, alternating upper then lower at the current block index. Every read from the unload window returns the next word in the same order. The engine reaches the store through its own block-indexed port. An init command rewinds both window pointers.

The read data is registered, so it appears one cycle after the read access. Any access that has no meaning raises a one-cycle error and changes no state. This covers an unmapped address, a write to a read-only location, and a read of the load window.

Top module: `kw_regfront`

## Requirements
- R1: After synchronous reset, config, block count, integrity word and all key words are zero. `rdata`, `err`, `core_init` and `core_next` are low, and both window pointers sit at block 0, upper word.
- R2: A write to 0x08 with bit 0 set makes `core_init` high for exactly the one cycle after the write. Bit 1 does the same for `core_next`. A read of 0x08 returns 0.
- R3: A read of 0x09 returns `core_ready` in bit 0 and `core_valid` in bit 1, with all other bits zero.
- R4: Register 0x0A holds the wrap select in bit 0 (1 = wrap), which drives `core_encrypt`, and the key-length select in bit 1, which drives `core_keylen`. The register reads back its value.
- R5: Register 0x0C holds the block count: the low CNT_W bits (16 by default) of the written word, readable and driven on `core_blocks`. The integrity word drives `core_a`, with its upper half at 0x0E and its lower half at 0x0F. When the engine asserts `core_a_we`, `core_a_in` is loaded into the integrity word, and it wins over a host write in the same cycle.
- R6: Key word n lives at 0x10+n, for n from 0 to 7. Word 0 drives `core_key[255:224]` and word 7 drives `core_key[31:0]`. Reads of key addresses return 0.
- R7: Successive writes to 0x20 alternate: the first goes to the upper half of the current block, the second to its lower half, and then the block index advances. The engine sees block i as {upper, lower} on `core_blk_rdata` when `core_blk_addr` is i.
- R8: Successive reads of 0x30 return stored words in the same upper-then-lower order, starting from block 0. This includes blocks that the engine wrote through `core_blk_we`.
- R9: An init command (a write to 0x08 with bit 0 set) returns both the load pointer and the unload pointer to block 0, upper word.
- R10: The following accesses raise `err` for one cycle, one cycle after the access, and change no register or pointer: an unmapped address, a write to 0x00–0x02, 0x09 or 0x30, and a read of 0x20. A faulting read also sets `rdata` to 0.
- R11: Read data appears on `rdata` one cycle after a read access, and holds until the next read.
- R12: Reads of 0x00, 0x01 and 0x02 return 0x6B777266, 0x726F6E74 and 0x00010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle error for a faulting access |
| core_init | output | 1 | Init pulse to engine |
| core_next | output | 1 | Next pulse to engine |
| core_ready | input | 1 | Engine ready |
| core_valid | input | 1 | Engine result valid |
| core_encrypt | output | 1 | Wrap (1) / unwrap (0) select |
| core_keylen | output | 1 | Key-length select |
| core_key | output | KEY_WORDS*32 | Key words, word 0 in the top bits |
| core_blocks | output | CNT_W | Block count |
| core_a | output | 64 | Integrity word |
| core_a_we | input | 1 | Engine integrity-word write |
| core_a_in | input | 64 | Engine integrity-word value |
| core_blk_addr | input | IDX_W | Engine block index |
| core_blk_we | input | 1 | Engine block write |
| core_blk_wdata | input | 64 | Engine block write data |
| core_blk_rdata | output | 64 | Block at `core_blk_addr` |

## Verification
A table of register accesses is tried first: identification reads, config and count round trips (including a count truncation), integrity halves, key reads and unmapped or read-only accesses. This separates the decode paths from the read mux. The block windows are then driven with four distinct words, so that a swapped bank or a missing pointer step shows as a wrong word. An engine-written block follows, and then an init in the middle of the stream, which distinguishes a pointer rewind from a pointer that keeps counting. Faulting window accesses placed between good ones show whether an error leaks into the pointers. A host write that collides with an engine write-back shows which side wins.

// File: rtl/kw_pkg.sv
// Package: kw_pkg
// Shared address map, identification constants and the decoded
// access structure used by the key-wrap register front end.
package kw_pkg;
    localparam logic [7:0] ADR_ID0   = 8'h00;
    localparam logic [7:0] ADR_ID1   = 8'h01;
    localparam logic [7:0] ADR_VER   = 8'h02;
    localparam logic [7:0] ADR_CTRL  = 8'h08;
    localparam logic [7:0] ADR_STAT  = 8'h09;
    localparam logic [7:0] ADR_CFG   = 8'h0A;
    localparam logic [7:0] ADR_CNT   = 8'h0C;
    localparam logic [7:0] ADR_AHI   = 8'h0E;
    localparam logic [7:0] ADR_ALO   = 8'h0F;
    localparam logic [7:0] ADR_LOAD  = 8'h20;
    localparam logic [7:0] ADR_DRAIN = 8'h30;

    localparam logic [31:0] ID_WORD0 = 32'h6B77_7266;
    localparam logic [31:0] ID_WORD1 = 32'h726F_6E74;
    localparam logic [31:0] VER_WORD = 32'h0001_0000;

    // One strobe per write target, plus read-window and fault flags.
    typedef struct packed {
        logic       ctrl_w;
        logic       cfg_w;
        logic       cnt_w;
        logic       ahi_w;
        logic       alo_w;
        logic       key_w;
        logic [2:0] key_idx;
        logic       load_w;
        logic       drain_r;
        logic       rd_ok;
        logic       fault;
    } kw_dec_t;
endpackage

// File: rtl/kw_decode.sv
// Module: kw_decode
// Turns a bus access into write strobes, a read-accept flag and a
// fault flag. Purely combinational; assumes addr/we stable while cs.
module kw_decode
    import kw_pkg::*;
#(
    parameter int KEY_WORDS = 8
) (
    input  logic       cs,
    input  logic       we,
    input  logic [7:0] addr,
    output kw_dec_t    dec
);
    // Classify the access by address and direction.
    always_comb begin
        dec = '0;
        dec.key_idx = addr[2:0];
        if (cs) begin
            casez (addr)
                ADR_ID0, ADR_ID1, ADR_VER, ADR_STAT: begin
                    if (we) dec.fault = 1'b1;
                    else    dec.rd_ok = 1'b1;
                end
                ADR_CTRL: begin
                    dec.ctrl_w = we;
                    dec.rd_ok  = !we;
                end
                ADR_CFG: begin
                    dec.cfg_w = we;
                    dec.rd_ok = !we;
                end
                ADR_CNT: begin
                    dec.cnt_w = we;
                    dec.rd_ok = !we;
                end
                ADR_AHI: begin
                    dec.ahi_w = we;
                    dec.rd_ok = !we;
                end
                ADR_ALO: begin
                    dec.alo_w = we;
                    dec.rd_ok = !we;
                end
                8'b0001_0???: begin
                    if (32'(addr[2:0]) < KEY_WORDS) begin
                        dec.key_w = we;
                        dec.rd_ok = !we;
                    end else begin
                        dec.fault = 1'b1;
                    end
                end
                ADR_LOAD: begin
                    if (we) dec.load_w = 1'b1;
                    else    dec.fault  = 1'b1;
                end
                ADR_DRAIN: begin
                    if (we) dec.fault = 1'b1;
                    else begin
                        dec.drain_r = 1'b1;
                        dec.rd_ok   = 1'b1;
                    end
                end
                default: dec.fault = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/kw_regs.sv
// Module: kw_regs
// Holds config, block count, integrity word and key words, and forms
// the init/next pulses. Assumes dec strobes are mutually exclusive.
module kw_regs
    import kw_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int KEY_WORDS = 8,
    localparam int KEY_W    = KEY_WORDS * 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  kw_dec_t          dec,
    input  logic [31:0]      wdata,
    input  logic             core_a_we,
    input  logic [63:0]      core_a_in,
    output logic             init_p,
    output logic             next_p,
    output logic             encrypt,
    output logic             keylen,
    output logic [CNT_W-1:0] count,
    output logic [63:0]      a_val,
    output logic [KEY_W-1:0] key_flat
);
    logic [31:0] key_q [KEY_WORDS];

    // Start pulses: one cycle per control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_p <= 1'b0;
            next_p <= 1'b0;
        end else begin
            init_p <= dec.ctrl_w & wdata[0];
            next_p <= dec.ctrl_w & wdata[1];
        end
    end

    // Mode, key length and block count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            encrypt <= 1'b0;
            keylen  <= 1'b0;
            count   <= '0;
        end else begin
            if (dec.cfg_w) begin
                encrypt <= wdata[0];
                keylen  <= wdata[1];
            end
            if (dec.cnt_w) count <= wdata[CNT_W-1:0];
        end
    end

    // Integrity word: engine write-back beats host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_val <= '0;
        end else if (core_a_we) begin
            a_val <= core_a_in;
        end else begin
            if (dec.ahi_w) a_val[63:32] <= wdata;
            if (dec.alo_w) a_val[31:0]  <= wdata;
        end
    end

    // Key words, word 0 placed in the top bits of the flat key.
    for (genvar k = 0; k < KEY_WORDS; k++) begin : g_key
        always_ff @(posedge clk) begin
            if (!rst_n)                             key_q[k] <= '0;
            else if (dec.key_w && dec.key_idx == 3'(k)) key_q[k] <= wdata;
        end
        assign key_flat[(KEY_WORDS-1-k)*32 +: 32] = key_q[k];
    end

    AST_INIT_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        init_p |=> (!init_p || $past(dec.ctrl_w && wdata[0]))); // R2
    AST_CORE_A_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        core_a_we |=> (a_val == $past(core_a_in))); // R5
endmodule

// File: rtl/kw_blockstore.sv
// Module: kw_blockstore
// Two-bank block store (upper/lower 32-bit halves) with auto-stepping
// load and drain pointers for the host and a block port for the engine.
// Assumes DEPTH is a power of two; engine writes win on collision.
module kw_blockstore #(
    parameter int DEPTH  = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic [31:0]      host_wdata,
    output logic [31:0]      host_rword,
    input  logic [IDX_W-1:0] core_addr,
    input  logic             core_we,
    input  logic [63:0]      core_wdata,
    output logic [63:0]      core_rdata
);
    logic [IDX_W-1:0] wr_idx, rd_idx;
    logic             wr_half, rd_half;
    logic [31:0]      host_rd_w [2];
    logic [31:0]      core_rd_w [2];

    // Load and drain pointers: half toggles, index steps after lower.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_idx  <= '0;
            wr_half <= 1'b0;
            rd_idx  <= '0;
            rd_half <= 1'b0;
        end else begin
            if (host_wr) begin
                wr_half <= !wr_half;
                if (wr_half) wr_idx <= wr_idx + 1'b1;
            end
            if (host_rd) begin
                rd_half <= !rd_half;
                if (rd_half) rd_idx <= rd_idx + 1'b1;
            end
        end
    end

    // Bank 0 holds upper halves, bank 1 lower halves.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [31:0] mem [DEPTH];

        // Bank write: host word then engine half (engine last, wins).
        always_ff @(posedge clk) begin
            if (host_wr && wr_half == 1'(b)) mem[wr_idx] <= host_wdata;
            if (core_we) mem[core_addr] <= core_wdata[(1-b)*32 +: 32];
        end

        assign host_rd_w[b] = mem[rd_idx];
        assign core_rd_w[b] = mem[core_addr];
    end

    assign host_rword = host_rd_w[rd_half];
    assign core_rdata = {core_rd_w[0], core_rd_w[1]};

    AST_PTR_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wr_idx == '0 && !wr_half && rd_idx == '0 && !rd_half)); // R9
    AST_LOAD_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !clr) |=> (wr_half != $past(wr_half))); // R7
    AST_DRAIN_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !clr) |=> (rd_half != $past(rd_half))); // R8
endmodule

// File: rtl/kw_regfront.sv
// Module: kw_regfront
// Top of the key-wrap register front end: bus decode, registers,
// block store and registered read mux. Assumes CNT_W <= 32.
module kw_regfront
    import kw_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int CNT_W     = 16,
    parameter int KEY_WORDS = 8,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int KEY_W    = KEY_WORDS * 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             we,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             err,
    output logic             core_init,
    output logic             core_next,
    input  logic             core_ready,
    input  logic             core_valid,
    output logic             core_encrypt,
    output logic             core_keylen,
    output logic [KEY_W-1:0] core_key,
    output logic [CNT_W-1:0] core_blocks,
    output logic [63:0]      core_a,
    input  logic             core_a_we,
    input  logic [63:0]      core_a_in,
    input  logic [IDX_W-1:0] core_blk_addr,
    input  logic             core_blk_we,
    input  logic [63:0]      core_blk_wdata,
    output logic [63:0]      core_blk_rdata
);
    kw_dec_t     dec;
    logic [31:0] drain_word;
    logic [31:0] rd_mux;

    kw_decode #(.KEY_WORDS(KEY_WORDS)) u_dec (
        .cs(cs), .we(we), .addr(addr), .dec(dec)
    );

    kw_regs #(.CNT_W(CNT_W), .KEY_WORDS(KEY_WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .dec(dec), .wdata(wdata),
        .core_a_we(core_a_we), .core_a_in(core_a_in),
        .init_p(core_init), .next_p(core_next),
        .encrypt(core_encrypt), .keylen(core_keylen),
        .count(core_blocks), .a_val(core_a), .key_flat(core_key)
    );

    kw_blockstore #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n),
        .clr(dec.ctrl_w & wdata[0]),
        .host_wr(dec.load_w), .host_rd(dec.drain_r),
        .host_wdata(wdata), .host_rword(drain_word),
        .core_addr(core_blk_addr), .core_we(core_blk_we),
        .core_wdata(core_blk_wdata), .core_rdata(core_blk_rdata)
    );

    // Read mux: value presented for an accepted read.
    always_comb begin
        case (addr)
            ADR_ID0:   rd_mux = ID_WORD0;
            ADR_ID1:   rd_mux = ID_WORD1;
            ADR_VER:   rd_mux = VER_WORD;
            ADR_STAT:  rd_mux = {30'b0, core_valid, core_ready};
            ADR_CFG:   rd_mux = {30'b0, core_keylen, core_encrypt};
            ADR_CNT:   rd_mux = 32'(core_blocks);
            ADR_AHI:   rd_mux = core_a[63:32];
            ADR_ALO:   rd_mux = core_a[31:0];
            ADR_DRAIN: rd_mux = drain_word;
            default:   rd_mux = '0;
        endcase
    end

    // Registered read data and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= dec.fault;
            if (dec.rd_ok)                rdata <= rd_mux;
            else if (dec.fault && !we)    rdata <= '0;
        end
    end

    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(core_encrypt) && $stable(core_keylen)
                 && $stable(core_blocks) && !core_init && !core_next)); // R10
    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(cs)); // R10
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cs) |-> $stable(rdata)); // R11
endmodule

// File: tb/tb_kw_regfront.sv
`timescale 1ns/1ps
module tb_kw_regfront;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs = 1'b0, we = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         err;
    logic         core_init, core_next;
    logic         core_ready = 1'b0, core_valid = 1'b0;
    logic         core_encrypt, core_keylen;
    logic [255:0] core_key;
    logic [15:0]  core_blocks;
    logic [63:0]  core_a;
    logic         core_a_we = 1'b0;
    logic [63:0]  core_a_in = '0;
    logic [5:0]   core_blk_addr = '0;
    logic         core_blk_we = 1'b0;
    logic [63:0]  core_blk_wdata = '0;
    logic [63:0]  core_blk_rdata;

    int  n_run = 0, n_fail = 0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    kw_regfront dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rdata), .err(err),
        .core_init(core_init), .core_next(core_next),
        .core_ready(core_ready), .core_valid(core_valid),
        .core_encrypt(core_encrypt), .core_keylen(core_keylen),
        .core_key(core_key), .core_blocks(core_blocks), .core_a(core_a),
        .core_a_we(core_a_we), .core_a_in(core_a_in),
        .core_blk_addr(core_blk_addr), .core_blk_we(core_blk_we),
        .core_blk_wdata(core_blk_wdata), .core_blk_rdata(core_blk_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // One bus access; returns at the falling edge after the capture edge.
    task automatic acc(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    // Vector: {we, addr, wdata, check_rdata, exp_rdata, exp_err}
    localparam int NV = 18;
    localparam logic [74:0] VEC [NV] = '{
        {1'b0, 8'h0A, 32'h0,         1'b1, 32'h0,         1'b0}, // R1 cfg zero
        {1'b0, 8'h00, 32'h0,         1'b1, 32'h6B777266,  1'b0}, // R12
        {1'b0, 8'h01, 32'h0,         1'b1, 32'h726F6E74,  1'b0}, // R12
        {1'b0, 8'h02, 32'h0,         1'b1, 32'h00010000,  1'b0}, // R12
        {1'b1, 8'h0A, 32'h3,         1'b0, 32'h0,         1'b0}, // R4
        {1'b0, 8'h0A, 32'h0,         1'b1, 32'h3,         1'b0}, // R4
        {1'b1, 8'h0C, 32'hFFFF1234,  1'b0, 32'h0,         1'b0}, // R5
        {1'b0, 8'h0C, 32'h0,         1'b1, 32'h1234,      1'b0}, // R5
        {1'b1, 8'h0E, 32'hA65959A6,  1'b0, 32'h0,         1'b0}, // R5
        {1'b1, 8'h0F, 32'h0000001F,  1'b0, 32'h0,         1'b0}, // R5
        {1'b0, 8'h0E, 32'h0,         1'b1, 32'hA65959A6,  1'b0}, // R5
        {1'b0, 8'h0F, 32'h0,         1'b1, 32'h0000001F,  1'b0}, // R5
        {1'b0, 8'h10, 32'h0,         1'b1, 32'h0,         1'b0}, // R6
        {1'b0, 8'h08, 32'h0,         1'b1, 32'h0,         1'b0}, // R2
        {1'b0, 8'h40, 32'h0,         1'b1, 32'h0,         1'b1}, // R10
        {1'b1, 8'h01, 32'h5,         1'b0, 32'h0,         1'b1}, // R10
        {1'b1, 8'h0A, 32'h0,         1'b0, 32'h0,         1'b0}, // R4
        {1'b0, 8'h0A, 32'h0,         1'b1, 32'h0,         1'b0}  // R4
    };

    initial begin
        #1000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", 64'(rdata), 64'h0);
        check("R1 err", 64'(err), 64'h0);
        check("R1 init", 64'(core_init), 64'h0);
        check("R1 encrypt", 64'(core_encrypt), 64'h0);
        check("R1 blocks", 64'(core_blocks), 64'h0);
        check("R1 a", core_a, 64'h0);
        check("R1 key", 64'(core_key[255:192]), 64'h0);

        for (int i = 0; i < NV; i++) begin
            acc(VEC[i][74], VEC[i][73:66], VEC[i][65:34]);
            check($sformatf("vec%0d err", i), 64'(err), 64'(VEC[i][0]));
            if (VEC[i][33])
                check($sformatf("vec%0d rdata", i), 64'(rdata), 64'(VEC[i][32:1]));
        end
        acc(1'b1, 8'h0A, 32'h1);
        check("R4 encrypt", 64'(core_encrypt), 64'h1);
        check("R4 keylen", 64'(core_keylen), 64'h0);
        check("R5 core_a", core_a, 64'hA65959A6_0000001F);

        // R6 key placement
        acc(1'b1, 8'h10, 32'h11111111);
        acc(1'b1, 8'h17, 32'h88888888);
        check("R6 key0", 64'(core_key[255:224]), 64'h11111111);
        check("R6 key7", 64'(core_key[31:0]), 64'h88888888);

        // R2 pulses
        acc(1'b1, 8'h08, 32'h1);
        check("R2 init hi", 64'(core_init), 64'h1);
        check("R2 next lo", 64'(core_next), 64'h0);
        @(negedge clk);
        check("R2 init one cycle", 64'(core_init), 64'h0);
        acc(1'b1, 8'h08, 32'h2);
        check("R2 next hi", 64'(core_next), 64'h1);
        check("R2 init lo", 64'(core_init), 64'h0);

        // R3 status
        core_ready = 1'b1; core_valid = 1'b0;
        acc(1'b0, 8'h09, 32'h0);
        check("R3 ready", 64'(rdata), 64'h1);
        core_ready = 1'b0; core_valid = 1'b1;
        acc(1'b0, 8'h09, 32'h0);
        check("R3 valid", 64'(rdata), 64'h2);

        // R7 load window
        acc(1'b1, 8'h08, 32'h1);
        acc(1'b1, 8'h20, 32'hAAAA0000);
        acc(1'b1, 8'h20, 32'hBBBB1111);
        acc(1'b1, 8'h20, 32'hCCCC2222);
        acc(1'b1, 8'h20, 32'hDDDD3333);
        core_blk_addr = 6'd0; #1;
        check("R7 block0", core_blk_rdata, 64'hAAAA0000_BBBB1111);
        core_blk_addr = 6'd1; #1;
        check("R7 block1", core_blk_rdata, 64'hCCCC2222_DDDD3333);

        // R8 drain window
        acc(1'b0, 8'h30, 32'h0); check("R8 w0", 64'(rdata), 64'hAAAA0000);
        acc(1'b0, 8'h30, 32'h0); check("R8 w1", 64'(rdata), 64'hBBBB1111);
        acc(1'b0, 8'h30, 32'h0); check("R8 w2", 64'(rdata), 64'hCCCC2222);
        acc(1'b0, 8'h30, 32'h0); check("R8 w3", 64'(rdata), 64'hDDDD3333);
        @(negedge clk);
        core_blk_addr = 6'd2; core_blk_we = 1'b1;
        core_blk_wdata = 64'hEEEE4444_FFFF5555;
        @(negedge clk);
        core_blk_we = 1'b0;
        acc(1'b0, 8'h30, 32'h0); check("R8 engine upper", 64'(rdata), 64'hEEEE4444);
        acc(1'b0, 8'h30, 32'h0); check("R8 engine lower", 64'(rdata), 64'hFFFF5555);

        // R9 rewind by init
        acc(1'b1, 8'h20, 32'h99990000);
        acc(1'b1, 8'h08, 32'h1);
        acc(1'b1, 8'h20, 32'h12345678);
        core_blk_addr = 6'd0; #1;
        check("R9 load rewound", core_blk_rdata, 64'h12345678_BBBB1111);
        acc(1'b0, 8'h30, 32'h0); check("R9 drain rewound", 64'(rdata), 64'h12345678);

        // R10 faulting window accesses leave pointers alone
        acc(1'b1, 8'h30, 32'h0); check("R10 write drain err", 64'(err), 64'h1);
        acc(1'b1, 8'h09, 32'h0); check("R10 write status err", 64'(err), 64'h1);
        @(negedge clk);
        check("R10 err one cycle", 64'(err), 64'h0);
        acc(1'b0, 8'h30, 32'h0); check("R10 drain ptr kept", 64'(rdata), 64'hBBBB1111);
        // R11 hold without reads
        @(negedge clk); @(negedge clk);
        check("R11 hold idle", 64'(rdata), 64'hBBBB1111);
        acc(1'b1, 8'h0C, 32'h7);
        check("R11 hold on write", 64'(rdata), 64'hBBBB1111);
        acc(1'b0, 8'h20, 32'h0);
        check("R10 read load err", 64'(err), 64'h1);
        check("R10 read load rdata", 64'(rdata), 64'h0);
        acc(1'b1, 8'h20, 32'h0BADF00D);
        core_blk_addr = 6'd0; #1;
        check("R10 load ptr kept", core_blk_rdata, 64'h12345678_0BADF00D);

        // R5 engine write-back wins over host write
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = 8'h0E; wdata = 32'h55555555;
        core_a_we = 1'b1; core_a_in = 64'hDEADBEEF_CAFEF00D;
        @(negedge clk);
        cs = 1'b0; we = 1'b0; core_a_we = 1'b0;
        acc(1'b0, 8'h0E, 32'h0); check("R5 engine wins hi", 64'(rdata), 64'hDEADBEEF);
        acc(1'b0, 8'h0F, 32'h0); check("R5 engine lo", 64'(rdata), 64'hCAFEF00D);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule